// File: doc/BRIEF.md
# System Control Port with Timer Channel 2 Gate

This block is a single byte-wide control and status port placed next to an interval timer. A write sets two control bits. One drives the gate input of timer channel 2. The other enables the speaker data path. A read returns one byte that holds these control bits, the live output level of timer channel 2, and a refresh indicator that toggles on its own.

The refresh indicator comes from a free-running divider. It changes level every `REFRESH_DIV` clock cycles. At the default of 2048 cycles with a 125 MHz clock, one half period is about 16.4 µs. The block also drives the gates of timer channels 0 and 1, and holds both high. The timer and any sound generation live outside this block.

Top module: `sys_ctrl_port`

## Requirements
- R1: While `rst_n` is low and after it is released, `ch2_gate`, `spk_en` and `rd_data` are 0, and the refresh indicator starts at 0.
- R2: A cycle with `wr_en` high sets `ch2_gate` to `wr_data[0]` and `spk_en` to `wr_data[1]` from the next clock edge.
- R3: Write bits 7:2 have no effect on any output. Without `wr_en`, `ch2_gate` and `spk_en` keep their values.
- R4: A cycle with `rd_en` high loads `rd_data` at the next edge with this layout: bit 0 is `ch2_gate`, bit 1 is `spk_en`, bit 4 is the refresh indicator, bit 5 is `ch2_out`, and bits 7:6 and 3:2 are 0.
- R5: The refresh indicator inverts every `REFRESH_DIV` clock cycles, counted from reset release. Reads and writes do not affect it. After k edges out of reset, its value is floor(k / `REFRESH_DIV`) mod 2.
- R6: Without `rd_en`, `rd_data` keeps its last value even when `ch2_out`, the control bits or the refresh indicator change.
- R7: When `wr_en` and `rd_en` are high in the same cycle, the read returns the control bits as they were before that write.
- R8: `ch01_gate` is always 2'b11, which holds the gates of timer channels 0 and 1 high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write byte; only bits 1:0 are used |
| rd_en | input | 1 | Read strobe |
| ch2_out | input | 1 | Output level of timer channel 2 |
| ch2_gate | output | 1 | Gate of timer channel 2 |
| spk_en | output | 1 | Speaker data enable |
| ch01_gate | output | 2 | Gates of timer channels 0 and 1 |
| rd_data | output | 8 | Read byte |

## Verification
The bench writes all 256 byte values and reads each one back while `ch2_out` follows a different data bit. A design that decoded the wrong bit, or let upper bits leak, would then show wrong gate, enable or zero fields.

A back-to-back read run with a short divider compares every refresh sample against the edge count since reset. An off-by-one wrap count shows up as a phase drift that grows over the run.

Holding periods while `ch2_out` and the refresh bit change expose a read register that updates without a strobe. A combined read and write catches a design that returns the new control bits too early.

// File: rtl/sys_ctrl_port.sv
module sys_ctrl_port #(
  parameter int REFRESH_DIV = 2048
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       rd_en,
  input  logic       ch2_out,
  output logic       ch2_gate,
  output logic       spk_en,
  output logic [1:0] ch01_gate,
  output logic [7:0] rd_data
);

  localparam int CNT_W    = (REFRESH_DIV > 1) ? $clog2(REFRESH_DIV) : 1;
  localparam int B_GATE   = 0;
  localparam int B_SPK    = 1;
  localparam int B_REFR   = 4;
  localparam int B_OUT    = 5;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(REFRESH_DIV - 1);

  logic [CNT_W-1:0] div_cnt;
  logic             refresh;
  logic [7:0]       status_byte;

  assign ch01_gate = 2'b11;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_cnt <= '0;
      refresh <= 1'b0;
    end else if (div_cnt == CNT_LAST) begin
      div_cnt <= '0;
      refresh <= ~refresh;
    end else begin
      div_cnt <= div_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ch2_gate <= 1'b0;
      spk_en   <= 1'b0;
    end else if (wr_en) begin
      ch2_gate <= wr_data[B_GATE];
      spk_en   <= wr_data[B_SPK];
    end
  end

  always_comb begin
    status_byte         = '0;
    status_byte[B_GATE] = ch2_gate;
    status_byte[B_SPK]  = spk_en;
    status_byte[B_REFR] = refresh;
    status_byte[B_OUT]  = ch2_out;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      rd_data <= '0;
    else if (rd_en)
      rd_data <= status_byte;
  end

  a_r2_write_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ch2_gate == $past(wr_data[0])) && (spk_en == $past(wr_data[1])));

  a_r3_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $past(rst_n)) |=> $stable(ch2_gate) && $stable(spk_en));

  a_r4_read_layout: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> (rd_data[5] == $past(ch2_out)) && (rd_data[1:0] == $past({spk_en, ch2_gate}))
              && (rd_data[7:6] == 2'b00) && (rd_data[3:2] == 2'b00));

  a_r5_refresh_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (div_cnt != CNT_LAST) |=> $stable(refresh));

  a_r6_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

// File: tb/sys_ctrl_port_tb.sv
module sys_ctrl_port_tb_top;
  localparam int DIV = 5;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic       ch2_out = 1'b0;
  logic       ch2_gate, spk_en;
  logic [1:0] ch01_gate;
  logic [7:0] rd_data;

  int unsigned cyc = 0;
  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  sys_ctrl_port #(.REFRESH_DIV(DIV)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .ch2_out(ch2_out), .ch2_gate(ch2_gate), .spk_en(spk_en),
    .ch01_gate(ch01_gate), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  function automatic logic exp_refr(input int unsigned edges);
    return logic'((edges / DIV) % 2);
  endfunction

  function automatic logic [7:0] pack(input logic o, input logic r, input logic s, input logic g);
    return {2'b00, o, r, 2'b00, s, g};
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [7:0] held;
    logic g, s;
    @(negedge clk);
    step();
    chk("R1 gate in reset", {7'd0, ch2_gate}, 8'h00);
    chk("R1 spk in reset", {7'd0, spk_en}, 8'h00);
    chk("R1 rd_data in reset", rd_data, 8'h00);
    chk("R8 ch01 gates in reset", {6'd0, ch01_gate}, 8'h03);
    rst_n = 1'b1;
    rd_en = 1'b1;
    step();
    rd_en = 1'b0;
    chk("R1 first read after reset", rd_data, pack(1'b0, 1'b0, 1'b0, 1'b0));

    for (int v = 0; v < 256; v++) begin
      wr_en = 1'b1; wr_data = 8'(v); ch2_out = wr_data[7] ^ wr_data[3];
      step();
      wr_en = 1'b0; wr_data = ~wr_data;
      chk("R2 gate from bit0", {7'd0, ch2_gate}, {7'd0, 1'(v & 1)});
      chk("R3 spk from bit1 only", {7'd0, spk_en}, {7'd0, 1'((v >> 1) & 1)});
      rd_en = 1'b1;
      step();
      rd_en = 1'b0;
      chk("R4 read layout", rd_data,
          pack(ch2_out, exp_refr(cyc - 1), 1'((v >> 1) & 1), 1'(v & 1)));
      held = rd_data;
      ch2_out = ~ch2_out;
      step(); step(); step();
      chk("R6 rd_data held", rd_data, held);
      chk("R3 ctrl held without write", {6'd0, spk_en, ch2_gate}, {6'd0, held[1], held[0]});
      chk("R8 ch01 gates", {6'd0, ch01_gate}, 8'h03);
    end

    wr_en = 1'b1; wr_data = 8'h03;
    step();
    wr_data = 8'h00; rd_en = 1'b1;
    step();
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R7 read sees pre-write bits", {6'd0, rd_data[1:0]}, 8'h03);
    chk("R7 write still lands", {6'd0, spk_en, ch2_gate}, 8'h00);

    rd_en = 1'b1;
    for (int k = 0; k < 6 * DIV; k++) begin
      wr_en = k[0]; wr_data = 8'(k);
      g = ch2_gate; s = spk_en;
      step();
      chk("R5 refresh phase", {7'd0, rd_data[4]}, {7'd0, exp_refr(cyc - 1)});
      chk("R4 continuous read ctrl", {6'd0, rd_data[1:0]}, {6'd0, s, g});
    end
    rd_en = 1'b0; wr_en = 1'b0;

    wr_en = 1'b1; wr_data = 8'hFF;
    step();
    wr_en = 1'b0; rst_n = 1'b0;
    step();
    chk("R1 mid-run reset ctrl", {6'd0, spk_en, ch2_gate}, 8'h00);
    chk("R1 mid-run reset rd_data", rd_data, 8'h00);
    rst_n = 1'b1; rd_en = 1'b1;
    for (int k = 0; k < 2 * DIV + 1; k++) begin
      step();
      chk("R5 refresh restarts at 0", {7'd0, rd_data[4]}, {7'd0, exp_refr(cyc - 1)});
    end
    rd_en = 1'b0;

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule